// File: doc/BRIEF.md
# Serial-Clocked Wiper Stepper with Tap Decoder

This block holds the six-bit position of one digital potentiometer wiper and turns it into a one-hot select for the 64 tap switches along a 63-segment resistor chain. The position can be set directly from a load port, or moved one tap at a time while a stepping mode is active. In stepping mode every serial clock rising edge moves the wiper: up toward the high terminal when the serial data line is high at that edge, down toward the low terminal when it is low. No byte framing and no acknowledge happen while the mode runs.

The surrounding serial interface produces single-cycle strobes that are already synchronised to the system clock: a serial-clock rising-edge strobe, the data line level, start and stop condition strobes, and a mode-entry pulse it raises once the stepping instruction has been acknowledged. The stepping mode runs until the next start or stop condition. The register write path uses the load port.

Top module: `wiper_stepper_top`

## Requirements
- R1: After reset the wiper position equals RESET_POS (0 by default), stepping mode is inactive and only tap_sel bit RESET_POS is set.
- R2: A pulse on mode_enter makes mode_active high from the next cycle; a clock strobe in the same cycle as mode_enter does not step.
- R3: While mode_active is high, a cycle with scl_rise high and sda_lvl high (1) raises wiper_pos by one in the following cycle.
- R4: While mode_active is high, a cycle with scl_rise high and sda_lvl low (0) lowers wiper_pos by one in the following cycle.
- R5: An upward step with wiper_pos at 63 leaves it at 63 (no wrap).
- R6: A downward step with wiper_pos at 0 leaves it at 0 (no wrap).
- R7: A start_cond or stop_cond strobe clears mode_active in the next cycle; a clock strobe in that same cycle does not step, and an exit strobe wins over a mode_enter in the same cycle.
- R8: load_en high writes load_val into wiper_pos in the next cycle, in or out of stepping mode, and takes priority over a step in the same cycle.
- R9: tap_sel has exactly one bit set at all times, bit number equal to wiper_pos (bit 0 is the low-terminal end).
- R10: With mode_active low, scl_rise strobes leave wiper_pos unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_rise | input | 1 | Single-cycle strobe for a serial clock rising edge |
| sda_lvl | input | 1 | Synchronised serial data level |
| start_cond | input | 1 | Strobe for a start condition |
| stop_cond | input | 1 | Strobe for a stop condition |
| mode_enter | input | 1 | Pulse after the stepping instruction is acknowledged |
| load_en | input | 1 | Direct write of the wiper position |
| load_val | input | POS_W | Value for the direct write |
| wiper_pos | output | POS_W | Current wiper position |
| tap_sel | output | 2**POS_W | One-hot tap switch enables |
| mode_active | output | 1 | Stepping mode is running |

## Verification
The bench builds the block with its default parameters, POS_W of 6 and RESET_POS of 0, so all 64 tap positions can be loaded and decoded in turn and both saturation ends are reached within a few steps after a load. Reset at zero puts the bottom rail right at the start, so a downward step straight after entering the mode probes the lower clamp. Same-cycle collisions of load, exit, entry and clock strobes are driven deliberately to pin down the priority order.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

endpackage

// File: rtl/wiper_mode_ctrl.sv
module wiper_mode_ctrl
    import wiper_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  scl_rise,
    input  logic  sda_lvl,
    input  logic  start_cond,
    input  logic  stop_cond,
    input  logic  mode_enter,
    output logic  active_o,
    output step_e step_o
);

    typedef struct packed {
        logic active;
    } mode_t;

    mode_t st_d, st_q;
    logic  exit_req;

    always_comb begin
        exit_req  = start_cond | stop_cond;
        st_d      = st_q;
        if (exit_req) begin
            st_d.active = 1'b0;
        end else if (mode_enter) begin
            st_d.active = 1'b1;
        end
        step_o = STEP_NONE;
        if (st_q.active && scl_rise && !exit_req) begin
            step_o = sda_lvl ? STEP_UP : STEP_DOWN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

    assert_exit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cond || stop_cond) |=> !active_o);

    assert_enter_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_enter && !start_cond && !stop_cond) |=> active_o);

    assert_idle_no_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (step_o == STEP_NONE));

endmodule

// File: rtl/wiper_counter.sv
module wiper_counter
    import wiper_pkg::*;
#(
    parameter int              POS_W     = 6,
    parameter logic [POS_W-1:0] RESET_POS = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_e            step_i,
    input  logic             load_en,
    input  logic [POS_W-1:0] load_val,
    output logic [POS_W-1:0] pos_o
);

    localparam logic [POS_W-1:0] MAX_POS = '1;
    localparam logic [POS_W-1:0] MIN_POS = '0;

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.pos = load_val;
        end else begin
            unique case (step_i)
                STEP_UP:   if (st_q.pos != MAX_POS) st_d.pos = st_q.pos + 1'b1;
                STEP_DOWN: if (st_q.pos != MIN_POS) st_d.pos = st_q.pos - 1'b1;
                default:   st_d.pos = st_q.pos;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pos <= RESET_POS;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o = st_q.pos;

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (pos_o == $past(load_val)));

    assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && step_i == STEP_UP && pos_o != MAX_POS) |=> (pos_o == $past(pos_o) + 1'b1));

    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && step_i == STEP_DOWN && pos_o != MIN_POS) |=> (pos_o == $past(pos_o) - 1'b1));

    assert_top_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && step_i == STEP_UP && pos_o == MAX_POS) |=> (pos_o == MAX_POS));

    assert_bottom_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && step_i == STEP_DOWN && pos_o == MIN_POS) |=> (pos_o == MIN_POS));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && step_i == STEP_NONE) |=> $stable(pos_o));

endmodule

// File: rtl/tap_onehot_decoder.sv
module tap_onehot_decoder #(
    parameter int POS_W = 6,
    localparam int TAPS = 1 << POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos_i,
    output logic [TAPS-1:0]  tap_o
);

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        localparam logic [POS_W-1:0] IDX = i[POS_W-1:0];
        assign tap_o[i] = (pos_i == IDX);
    end

    assert_single_tap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_o) == 1);

    assert_tap_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tap_o[pos_i] == 1'b1);

endmodule

// File: rtl/wiper_stepper_top.sv
module wiper_stepper_top
    import wiper_pkg::*;
#(
    parameter int               POS_W     = 6,
    parameter logic [POS_W-1:0] RESET_POS = '0,
    localparam int              TAPS      = 1 << POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             sda_lvl,
    input  logic             start_cond,
    input  logic             stop_cond,
    input  logic             mode_enter,
    input  logic             load_en,
    input  logic [POS_W-1:0] load_val,
    output logic [POS_W-1:0] wiper_pos,
    output logic [TAPS-1:0]  tap_sel,
    output logic             mode_active
);

    step_e step_w;

    wiper_mode_ctrl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .sda_lvl    (sda_lvl),
        .start_cond (start_cond),
        .stop_cond  (stop_cond),
        .mode_enter (mode_enter),
        .active_o   (mode_active),
        .step_o     (step_w)
    );

    wiper_counter #(
        .POS_W     (POS_W),
        .RESET_POS (RESET_POS)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step_w),
        .load_en  (load_en),
        .load_val (load_val),
        .pos_o    (wiper_pos)
    );

    tap_onehot_decoder #(
        .POS_W (POS_W)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .pos_i (wiper_pos),
        .tap_o (tap_sel)
    );

endmodule

// File: tb/wiper_stepper_top_test.sv
module wiper_stepper_top_test;

    localparam int POS_W = 6;
    localparam int TAPS  = 1 << POS_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             scl_rise = 1'b0;
    logic             sda_lvl = 1'b0;
    logic             start_cond = 1'b0;
    logic             stop_cond = 1'b0;
    logic             mode_enter = 1'b0;
    logic             load_en = 1'b0;
    logic [POS_W-1:0] load_val = '0;
    logic [POS_W-1:0] wiper_pos;
    logic [TAPS-1:0]  tap_sel;
    logic             mode_active;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    wiper_stepper_top uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise    (scl_rise),
        .sda_lvl     (sda_lvl),
        .start_cond  (start_cond),
        .stop_cond   (stop_cond),
        .mode_enter  (mode_enter),
        .load_en     (load_en),
        .load_val    (load_val),
        .wiper_pos   (wiper_pos),
        .tap_sel     (tap_sel),
        .mode_active (mode_active)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle of strobes, then return at the next falling edge,
    // after the registers have taken the values.
    task automatic cycle(input logic scl, input logic sda, input logic sta,
                         input logic sto, input logic ent, input logic ld,
                         input logic [POS_W-1:0] val);
        scl_rise = scl; sda_lvl = sda; start_cond = sta; stop_cond = sto;
        mode_enter = ent; load_en = ld; load_val = val;
        @(negedge clk);
        scl_rise = 0; start_cond = 0; stop_cond = 0; mode_enter = 0; load_en = 0;
    endtask

    task automatic step(input logic up);
        cycle(1, up, 0, 0, 0, 0, '0);
    endtask

    task automatic do_load(input logic [POS_W-1:0] v);
        cycle(0, 0, 0, 0, 0, 1, v);
    endtask

    task automatic test_reset;
        check("R1 pos", 64'(wiper_pos), 64'd0);
        check("R1 mode", 64'(mode_active), 64'd0);
        check("R1 tap", tap_sel, 64'd1);
    endtask

    task automatic test_idle_ignored;
        step(1); step(1);
        check("R10 idle steps", 64'(wiper_pos), 64'd0);
    endtask

    task automatic test_enter_and_bottom;
        cycle(1, 1, 0, 0, 1, 0, '0);
        check("R2 no step on enter", 64'(wiper_pos), 64'd0);
        check("R2 active", 64'(mode_active), 64'd1);
        step(0);
        check("R6 bottom clamp", 64'(wiper_pos), 64'd0);
    endtask

    task automatic test_up_down;
        for (int k = 0; k < 5; k++) step(1);
        check("R3 five up", 64'(wiper_pos), 64'd5);
        step(0); step(0);
        check("R4 two down", 64'(wiper_pos), 64'd3);
        step(1); step(0); step(1);
        check("R3 R4 mixed", 64'(wiper_pos), 64'd4);
        check("R9 tap", tap_sel, 64'd1 << 4);
    endtask

    task automatic test_top_clamp;
        do_load(6'd62);
        check("R8 load in mode", 64'(wiper_pos), 64'd62);
        step(1);
        check("R3 to top", 64'(wiper_pos), 64'd63);
        step(1); step(1);
        check("R5 top clamp", 64'(wiper_pos), 64'd63);
        check("R9 top tap", tap_sel, 64'd1 << 63);
    endtask

    task automatic test_load_priority;
        cycle(1, 1, 0, 0, 0, 1, 6'd20);
        check("R8 load over step", 64'(wiper_pos), 64'd20);
    endtask

    task automatic test_stop_exit;
        cycle(1, 1, 0, 1, 0, 0, '0);
        check("R7 stop no step", 64'(wiper_pos), 64'd20);
        check("R7 stop clears", 64'(mode_active), 64'd0);
        step(1); step(0);
        check("R10 after stop", 64'(wiper_pos), 64'd20);
    endtask

    task automatic test_start_exit;
        cycle(0, 0, 0, 0, 1, 0, '0);
        check("R2 re-enter", 64'(mode_active), 64'd1);
        step(0);
        check("R4 after re-enter", 64'(wiper_pos), 64'd19);
        cycle(1, 0, 1, 0, 0, 0, '0);
        check("R7 start no step", 64'(wiper_pos), 64'd19);
        check("R7 start clears", 64'(mode_active), 64'd0);
        cycle(0, 0, 0, 1, 1, 0, '0);
        check("R7 exit beats enter", 64'(mode_active), 64'd0);
        do_load(6'd7);
        check("R8 load idle", 64'(wiper_pos), 64'd7);
    endtask

    task automatic test_decode_all;
        for (int v = 0; v < TAPS; v++) begin
            do_load(v[POS_W-1:0]);
            check("R9 decode", tap_sel, 64'd1 << v);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset;
        rst_n = 1'b1;
        @(negedge clk);
        test_reset;
        test_idle_ignored;
        test_enter_and_bottom;
        test_up_down;
        test_top_clamp;
        test_load_priority;
        test_stop_exit;
        test_start_exit;
        test_decode_all;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #4000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule